// File: doc/BRIEF.md
# Adaptive Two-Ring Clock Replacement Engine

This block decides which entry of a small fully associative tag directory is given up when a new tag must be brought in. Resident tags live in two clock rings. The first holds tags that have been referenced once since they came in. The second holds tags that have proven reuse. Each ring has its own hand, and each resident slot has one reference bit. Two ghost lists keep the tags most recently pushed out of each ring, with no data. A hit in a ghost list steers the adaptive target size of the first ring toward the kind of reuse that the workload shows.

Lookups arrive one at a time over a valid/ready handshake. Every accepted lookup produces exactly one single-cycle response. The response says whether the tag is resident and which slot holds it, or which slot must be refilled. On a miss in a full directory it also gives the tag that was displaced. The hands advance by at most one entry per clock, so a replacing miss holds `req_ready` low for a few cycles. Each ring is kept as an ordered list whose head is the hand position, so "behind the hand" is the list tail.

Top module: `car_engine`

## Requirements
- R1: A lookup whose tag is resident in either ring reports `resp_hit`=1 with the slot holding it and no victim. It sets that slot's reference bit and changes no list membership or order.
- R2: A miss on a tag found in neither ghost list appends the tag behind the hand of the first ring with a cleared reference bit. While fewer than C tags are resident, the refill slot is the lowest-numbered slot never used since reset.
- R3: `resp_victim_valid` is 1 exactly when the miss found C tags already resident.
- R4: A first-ring hand that reaches a set reference bit moves the entry behind the second-ring hand, clears the bit, and keeps scanning. At a clear bit it evicts the entry and appends its tag as the newest tag of the first ghost list.
- R5: A second-ring hand that reaches a set bit clears it and advances, so the entry goes behind the hand. At a clear bit it evicts the entry and appends the tag as the newest tag of the second ghost list.
- R6: Each scan step works on the first ring when its occupancy is at least max(1, p), and on the second ring otherwise. p is the value held before this lookup.
- R7: Before admitting a tag found in neither ghost list, the engine drops the oldest tag of the first ghost list if the first ring plus the first ghost list hold C tags. Failing that, it drops the oldest tag of the second ghost list if all four lists hold 2C tags.
- R8: p starts at 0 and moves by one per ghost hit. A first-ghost hit raises it, saturating at C, and a second-ghost hit lowers it, saturating at 0. The change takes effect after that miss's replacement.
- R9: A tag found in a ghost list is removed from it and appended behind the second-ring hand with a cleared reference bit.
- R10: `req_ready` is high only while the engine is idle. Each accepted lookup yields one `resp_valid` pulse at most 2C+3 cycles after acceptance, and a scan takes at most 2C steps.
- R11: Reset empties all four lists, clears p and the slot usage, and leaves `req_ready`=1 and `resp_valid`=0.
- R12: No more than C tags are resident and no more than 2C tags are held across all four lists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and able to take a lookup |
| req_tag | input | TAG_W | Tag being looked up |
| resp_valid | output | 1 | One-cycle pulse: response fields are valid |
| resp_hit | output | 1 | 1 when the tag was resident |
| resp_slot | output | $clog2(C) | Slot holding the tag (hit) or slot to refill (miss) |
| resp_victim_valid | output | 1 | A resident tag was displaced by this miss |
| resp_victim_tag | output | TAG_W | The displaced tag |

## Verification
The assertions assume that a requester never offers a tag which is already resident under a second slot. They also assume that `req_tag` is only sampled on a cycle where `req_valid` and `req_ready` are both high, so a duplicate can only arise from a lookup path that the engine itself forbids. The stimulus keeps to this assumption because it issues one lookup at a time and waits for the response pulse before the next. Each response is compared field by field against a behavioural model of the same policy kept in the bench. The tag streams include fills, reference-bit patterns, ghost hits in both lists, cyclic sweeps larger than the directory, random draws over a small tag space, and a reset in mid-stream.

// File: rtl/car_pkg.sv
package car_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOOK  = 2'd1,
      ST_SCAN  = 2'd2,
      ST_ADMIT = 2'd3
   } car_state_e;

   // lower bound used when choosing which ring the hand sweeps
   function automatic int floor_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/car_list.sv
// Ordered list: head at index 0, tail at count-1.
// One removal at any index and one append may happen in the same cycle.
module car_list #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rm,
   input  logic [$clog2(DEPTH)-1:0]   rm_idx,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   output logic [W-1:0]               ents [DEPTH],
   output logic [$clog2(DEPTH+1)-1:0] cnt
);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("car_list: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("car_list: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  q    [DEPTH];
   logic [W-1:0]  ext  [DEPTH+1];
   logic [W-1:0]  nxt  [DEPTH];
   logic [CW-1:0] cnt_q, cnt_mid, cnt_nxt;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) ext[i] = q[i];
      ext[DEPTH] = '0;
      cnt_mid = cnt_q - CW'(rm);
      for (int i = 0; i < DEPTH; i++) begin
         if (rm && i >= int'(rm_idx)) nxt[i] = ext[i+1];
         else                         nxt[i] = q[i];
         if (push && i == int'(cnt_mid)) nxt[i] = push_data;
      end
      cnt_nxt = cnt_mid + CW'(push);
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n) q[g] <= '0;
            else        q[g] <= nxt[g];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign ents = q;
   assign cnt  = cnt_q;

   AST_LIST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !rm) |-> (int'(cnt_q) < DEPTH)); // R12
   AST_LIST_RM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rm |-> (int'(rm_idx) < int'(cnt_q))); // R12

endmodule

// File: rtl/car_engine.sv
module car_engine #(
   parameter int C     = 8,
   parameter int TAG_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [TAG_W-1:0]     req_tag,
   output logic                 resp_valid,
   output logic                 resp_hit,
   output logic [$clog2(C)-1:0] resp_slot,
   output logic                 resp_victim_valid,
   output logic [TAG_W-1:0]     resp_victim_tag
);
   import car_pkg::*;

   localparam int SW  = $clog2(C);
   localparam int EW  = TAG_W + SW;
   localparam int GD  = C + 1;
   localparam int GIW = $clog2(GD);
   localparam int TCW = $clog2(C + 1);
   localparam int GCW = $clog2(GD + 1);
   localparam int PW  = $clog2(2*C + 2) + 1;

   generate
      if (C < 2) begin : g_bad_c
         $error("car_engine: C must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("car_engine: TAG_W must be at least 1");
      end
   endgenerate

   car_state_e        st;
   logic [TAG_W-1:0]  tag_q, vt_q;
   logic [PW-1:0]     p_q, scan_n;
   logic [C-1:0]      ref_q, used_q;
   logic [SW-1:0]     slot_q;
   logic              hit_q, vv_q, rv_q, g1_q, g2_q;
   logic [GIW-1:0]    gidx_q;

   logic [EW-1:0]     t1_e [C];
   logic [EW-1:0]     t2_e [C];
   logic [TAG_W-1:0]  b1_e [GD];
   logic [TAG_W-1:0]  b2_e [GD];
   logic [TCW-1:0]    t1_n, t2_n;
   logic [GCW-1:0]    b1_n, b2_n;

   logic              t1_rm, t1_push, t2_rm, t2_push, b1_rm, b1_push, b2_rm, b2_push;
   logic [SW-1:0]     t1_ri, t2_ri;
   logic [GIW-1:0]    b1_ri, b2_ri;
   logic [EW-1:0]     t1_pd, t2_pd;
   logic [TAG_W-1:0]  b1_pd, b2_pd;

   car_list #(.W(EW), .DEPTH(C)) u_t1 (
      .clk(clk), .rst_n(rst_n), .rm(t1_rm), .rm_idx(t1_ri),
      .push(t1_push), .push_data(t1_pd), .ents(t1_e), .cnt(t1_n));
   car_list #(.W(EW), .DEPTH(C)) u_t2 (
      .clk(clk), .rst_n(rst_n), .rm(t2_rm), .rm_idx(t2_ri),
      .push(t2_push), .push_data(t2_pd), .ents(t2_e), .cnt(t2_n));
   car_list #(.W(TAG_W), .DEPTH(GD)) u_b1 (
      .clk(clk), .rst_n(rst_n), .rm(b1_rm), .rm_idx(b1_ri),
      .push(b1_push), .push_data(b1_pd), .ents(b1_e), .cnt(b1_n));
   car_list #(.W(TAG_W), .DEPTH(GD)) u_b2 (
      .clk(clk), .rst_n(rst_n), .rm(b2_rm), .rm_idx(b2_ri),
      .push(b2_push), .push_data(b2_pd), .ents(b2_e), .cnt(b2_n));

   // occupancy
   logic [PW-1:0] res_n, all_n;
   logic          full;
   assign res_n = PW'(t1_n) + PW'(t2_n);
   assign all_n = res_n + PW'(b1_n) + PW'(b2_n);
   assign full  = (res_n == PW'(C));

   // associative searches
   logic              th, g1h, g2h;
   logic [SW-1:0]     th_slot, fs;
   logic [GIW-1:0]    g1i, g2i;
   always_comb begin
      th = 1'b0; th_slot = '0;
      for (int i = 0; i < C; i++) begin
         if (i < int'(t1_n) && t1_e[i][EW-1:SW] == tag_q) begin
            th = 1'b1; th_slot = t1_e[i][SW-1:0];
         end
         if (i < int'(t2_n) && t2_e[i][EW-1:SW] == tag_q) begin
            th = 1'b1; th_slot = t2_e[i][SW-1:0];
         end
      end
      g1h = 1'b0; g1i = '0; g2h = 1'b0; g2i = '0;
      for (int i = 0; i < GD; i++) begin
         if (i < int'(b1_n) && b1_e[i] == tag_q) begin g1h = 1'b1; g1i = GIW'(i); end
         if (i < int'(b2_n) && b2_e[i] == tag_q) begin g2h = 1'b1; g2i = GIW'(i); end
      end
      fs = '0;
      for (int i = C-1; i >= 0; i--) if (!used_q[i]) fs = SW'(i);
   end

   // hand selection
   logic          use_t1, hd_ref;
   logic [EW-1:0] hd;
   logic [SW-1:0] hd_slot;
   assign use_t1  = int'(t1_n) >= floor_one(int'(p_q));
   assign hd      = use_t1 ? t1_e[0] : t2_e[0];
   assign hd_slot = hd[SW-1:0];
   assign hd_ref  = ref_q[hd_slot];

   // list control
   always_comb begin
      t1_rm = 1'b0; t1_ri = '0; t1_push = 1'b0; t1_pd = {tag_q, slot_q};
      t2_rm = 1'b0; t2_ri = '0; t2_push = 1'b0; t2_pd = {tag_q, slot_q};
      b1_rm = 1'b0; b1_ri = '0; b1_push = 1'b0; b1_pd = hd[EW-1:SW];
      b2_rm = 1'b0; b2_ri = '0; b2_push = 1'b0; b2_pd = hd[EW-1:SW];
      if (st == ST_SCAN) begin
         if (use_t1) begin
            t1_rm = 1'b1;
            if (hd_ref) begin t2_push = 1'b1; t2_pd = hd; end
            else        b1_push = 1'b1;
         end else begin
            t2_rm = 1'b1;
            if (hd_ref) begin t2_push = 1'b1; t2_pd = hd; end
            else        b2_push = 1'b1;
         end
      end else if (st == ST_ADMIT) begin
         if (g1_q) begin
            b1_rm = 1'b1; b1_ri = gidx_q; t2_push = 1'b1;
         end else if (g2_q) begin
            b2_rm = 1'b1; b2_ri = gidx_q; t2_push = 1'b1;
         end else begin
            if (PW'(t1_n) + PW'(b1_n) == PW'(C)) b1_rm = 1'b1;
            else if (all_n == PW'(2*C))          b2_rm = 1'b1;
            t1_push = 1'b1;
         end
      end
   end

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; tag_q <= '0; vt_q <= '0; p_q <= '0; scan_n <= '0;
         ref_q <= '0; used_q <= '0; slot_q <= '0; hit_q <= 1'b0; vv_q <= 1'b0;
         rv_q <= 1'b0; g1_q <= 1'b0; g2_q <= 1'b0; gidx_q <= '0;
      end else begin
         rv_q <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               tag_q <= req_tag;
               st    <= ST_LOOK;
            end
            ST_LOOK: if (th) begin
               ref_q[th_slot] <= 1'b1;
               slot_q <= th_slot; hit_q <= 1'b1; vv_q <= 1'b0; rv_q <= 1'b1;
               st     <= ST_IDLE;
            end else begin
               g1_q   <= g1h;
               g2_q   <= g2h;
               gidx_q <= g1h ? g1i : g2i;
               hit_q  <= 1'b0;
               if (full) begin
                  scan_n <= '0;
                  st     <= ST_SCAN;
               end else begin
                  slot_q     <= fs;
                  used_q[fs] <= 1'b1;
                  vv_q       <= 1'b0;
                  st         <= ST_ADMIT;
               end
            end
            ST_SCAN: begin
               scan_n <= scan_n + 1'b1;
               if (hd_ref) ref_q[hd_slot] <= 1'b0;
               else begin
                  slot_q <= hd_slot; vv_q <= 1'b1; vt_q <= hd[EW-1:SW];
                  st     <= ST_ADMIT;
               end
            end
            default: begin
               ref_q[slot_q] <= 1'b0;
               if (g1_q && p_q < PW'(C))      p_q <= p_q + 1'b1;
               else if (g2_q && p_q != '0)    p_q <= p_q - 1'b1;
               rv_q <= 1'b1;
               st   <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready         = (st == ST_IDLE);
   assign resp_valid        = rv_q;
   assign resp_hit          = hit_q;
   assign resp_slot         = slot_q;
   assign resp_victim_valid = vv_q;
   assign resp_victim_tag   = vt_q;

   AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      res_n <= PW'(C)); // R12
   AST_ALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      all_n <= PW'(2*C)); // R12
   AST_HIT_NO_HAND: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOOK && th) |=> ($stable(t1_n) && $stable(t2_n) && $stable(b1_n) && $stable(b2_n))); // R1
   AST_VICTIM_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOOK && !th && !full) |=> (st == ST_ADMIT)); // R3
   AST_ADMIT_REF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADMIT) |=> !ref_q[slot_q]); // R2
   AST_P_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      p_q <= PW'(C)); // R8
   AST_P_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(p_q) |-> (p_q == $past(p_q) + 1'b1 || p_q == $past(p_q) - 1'b1)); // R8
   AST_SCAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SCAN) |-> (scan_n < PW'(2*C))); // R10
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rv_q |=> !rv_q); // R10

endmodule

// File: tb/car_engine_tb.sv
module car_engine_tb;
   localparam int C     = 8;
   localparam int TAG_W = 8;
   localparam int SW    = $clog2(C);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [TAG_W-1:0] req_tag = '0;
   logic req_ready, resp_valid, resp_hit, resp_victim_valid;
   logic [SW-1:0] resp_slot;
   logic [TAG_W-1:0] resp_victim_tag;

   always #10 clk = ~clk;

   car_engine #(.C(C), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_tag(req_tag), .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_slot(resp_slot), .resp_victim_valid(resp_victim_valid),
      .resp_victim_tag(resp_victim_tag));

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   // behavioural model: list 0 = first ring, 1 = second ring, 2/3 = ghosts
   int mt [4][0:19];
   int ms [4][0:19];
   int mn [4];
   int mref  [0:C-1];
   int mused [0:C-1];
   int mp;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic mreset();
      for (int l = 0; l < 4; l++) mn[l] = 0;
      for (int s = 0; s < C; s++) begin mref[s] = 0; mused[s] = 0; end
      mp = 0;
   endtask

   function automatic int mfind(input int l, input int tg);
      for (int i = 0; i < mn[l]; i++) if (mt[l][i] == tg) return i;
      return -1;
   endfunction

   task automatic mrem(input int l, input int idx);
      for (int i = idx; i < mn[l] - 1; i++) begin
         mt[l][i] = mt[l][i+1]; ms[l][i] = ms[l][i+1];
      end
      mn[l]--;
   endtask

   task automatic mpush(input int l, input int tg, input int sl);
      mt[l][mn[l]] = tg; ms[l][mn[l]] = sl; mn[l]++;
   endtask

   task automatic mstep(input int tg, output int eh, output int es, output int evv, output int evt);
      int i1, i2, g1, g2, s, t;
      i1 = mfind(0, tg); i2 = mfind(1, tg);
      evv = 0; evt = 0; eh = 0; es = 0;
      if (i1 >= 0 || i2 >= 0) begin
         eh = 1;
         es = (i1 >= 0) ? ms[0][i1] : ms[1][i2];
         mref[es] = 1;
         return;
      end
      g1 = mfind(2, tg); g2 = mfind(3, tg);
      if (mn[0] + mn[1] == C) begin
         evv = 1;
         forever begin
            if (mn[0] >= ((mp < 1) ? 1 : mp)) begin
               t = mt[0][0]; s = ms[0][0]; mrem(0, 0);
               if (mref[s] != 0) begin mref[s] = 0; mpush(1, t, s); end
               else begin mpush(2, t, 0); evt = t; es = s; break; end
            end else begin
               t = mt[1][0]; s = ms[1][0]; mrem(1, 0);
               if (mref[s] != 0) begin mref[s] = 0; mpush(1, t, s); end
               else begin mpush(3, t, 0); evt = t; es = s; break; end
            end
         end
      end else begin
         es = -1;
         for (int k = C-1; k >= 0; k--) if (mused[k] == 0) es = k;
         mused[es] = 1;
      end
      mref[es] = 0;
      if (g1 >= 0) begin
         mp = (mp < C) ? mp + 1 : mp;
         mrem(2, g1); mpush(1, tg, es);
      end else if (g2 >= 0) begin
         mp = (mp > 0) ? mp - 1 : 0;
         mrem(3, g2); mpush(1, tg, es);
      end else begin
         if (mn[0] + mn[2] == C) mrem(2, 0);
         else if (mn[0] + mn[1] + mn[2] + mn[3] == 2*C) mrem(3, 0);
         mpush(0, tg, es);
      end
   endtask

   task automatic lookup(input int tg);
      int eh, es, evv, evt, lat;
      mstep(tg, eh, es, evv, evt);
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready while idle", int'(req_ready), 1);
      req_valid = 1'b1; req_tag = TAG_W'(tg);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!resp_valid && lat < 60) begin @(negedge clk); lat++; end
      chk(resp_valid == 1'b1 && lat <= 2*C + 3, "R10 response latency", lat, 2*C + 3);
      chk(int'(resp_hit) == eh, "R1 R2 hit flag", int'(resp_hit), eh);
      chk(int'(resp_slot) == es, "R1 R2 slot", int'(resp_slot), es);
      chk(int'(resp_victim_valid) == evv, "R3 victim present", int'(resp_victim_valid), evv);
      if (evv != 0)
         chk(int'(resp_victim_tag) == evt, "R4 R5 R6 R7 R8 R9 victim tag", int'(resp_victim_tag), evt);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mreset();
   endtask

   initial begin
      mreset();
      do_reset();
      // R11: idle outputs after reset
      chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
      chk(resp_valid == 1'b0, "R11 no response after reset", int'(resp_valid), 0);

      // R2: fill, R1: hits set reference bits
      for (int t = 0; t < C; t++) lookup(t);
      for (int t = 0; t < 4; t++) lookup(t);
      // R4: first-ring sweep promotes referenced entries, evicts the rest
      lookup(8); lookup(9);
      // R9 R8: first ghost list hit raises p
      lookup(4); lookup(5);
      for (int t = 10; t < 16; t++) lookup(t);
      // R5: second-ring traffic and second ghost hits
      for (int t = 0; t < 4; t++) lookup(t);
      for (int t = 16; t < 24; t++) lookup(t);
      for (int t = 0; t < 6; t++) lookup(t);

      // R6 R7: cyclic sweep larger than the directory
      for (int r = 0; r < 12; r++) for (int t = 30; t < 42; t++) lookup(t);

      // random mix over a small tag space with a hot subset
      for (int n = 0; n < 2500; n++) begin
         if ($urandom_range(0, 3) == 0) lookup(int'($urandom_range(50, 53)));
         else                            lookup(int'($urandom_range(0, 19)));
      end

      // R11: reset mid-stream clears every list and slot usage
      do_reset();
      chk(req_ready == 1'b1, "R11 ready after second reset", int'(req_ready), 1);
      for (int t = 0; t < C; t++) begin
         lookup(100 + t);
         chk(int'(resp_victim_valid) == 0 && int'(resp_slot) == t,
             "R11 refill order after reset", int'(resp_slot), t);
      end
      for (int n = 0; n < 600; n++) lookup(int'($urandom_range(100, 115)));

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errs++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

endmodule